// File: doc/BRIEF.md
# Transaction-Layer Packet Header Classifier

This block watches a stream of PCI Express transaction-layer packets, one 32-bit doubleword per cycle. The stream uses a valid/ready handshake with start-of-packet and end-of-packet markers. A direction flag sampled on the first beat says whether the packet travels downstream (0) or upstream (1). The block reads the first header doubleword and works out three things from it: the header size, whether a payload follows, and the routing class. It then counts the beats to the end marker and checks the payload size against the length field.

For each packet it produces one result record. The record holds the routing class, the message routing code, the header size, the payload flag, the traffic class to use and a malformed flag. The record appears one cycle after the last beat is accepted. It stays on the outputs until the consumer takes it, and no further input is accepted while it waits.

A control doubleword written at byte address 0x40 turns on isochronous mode and picks the traffic class used for upstream traffic.

Top module: `tlp_hdr_classifier`

## Requirements
- R1: Header doubleword 0 has the following layout: format in bits [30:29], type in [28:24], traffic class in [22:20], digest in bit 15 and length in [9:0]. Format bit 30 set gives `res_has_data`=1. Format bit 29 set gives `res_hdr4`=1, meaning a 4-doubleword header; otherwise the header is 3 doublewords.
- R2: The type field sets `res_class`. Types 00000, 00001 (memory) and 00010 (IO) give 0 (address routed). Types 00100 and 00101 (configuration) give 1 (ID routed). Types 10rrr (message) give 2 (implicit), with `res_route`=rrr. Every other type gives 3.
- R3: A packet with a payload whose length field is 0 (meaning 1024) or greater than 64 is malformed.
- R4: For a packet with a payload, the number of beats after the header must equal the length field plus one when the digest bit is set. Any other count is malformed.
- R5: A packet whose end marker comes before its header is complete (fewer than 3 or 4 beats) is malformed.
- R6: A downstream configuration, IO or message packet with a traffic class other than 0 is malformed. A downstream memory packet is accepted with any class. For downstream packets, `res_tc` carries the header's class.
- R7: For upstream packets, `res_tc` is the programmed class when isochronous mode is on, and 0 when it is off.
- R8: After reset, isochronous mode is off and the programmed class is 0. A write to byte address 0x40 loads the enable from data bit 26 and the class from bits [18:16]. Writes to any other address change nothing.
- R9: `res_valid` rises in the cycle after the end-of-packet beat is accepted. The record holds steady while `res_ready` is low, and `in_ready` is low during that stall. After the record is taken, `res_valid` falls unless a new end beat was accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_addr | input | 8 | Control write byte address |
| cfg_wdata | input | 32 | Control write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 32 | Packet doubleword |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| in_up | input | 1 | Direction, sampled on first beat: 1 upstream |
| res_valid | output | 1 | Result record valid |
| res_ready | input | 1 | Consumer takes the record |
| res_class | output | 2 | Routing class |
| res_route | output | 3 | Message routing code |
| res_hdr4 | output | 1 | Header is 4 doublewords |
| res_has_data | output | 1 | Packet carries a payload |
| res_tc | output | 3 | Traffic class to use |
| res_malformed | output | 1 | Packet violates a rule |

## Verification
The assertions assume well-framed input: in_sop marks the first beat of every packet and in_eop its last. No packet starts while another is open, and in_up is valid on the first beat. The bench builds every packet as a whole array of beats, so the markers always match the array ends. It holds in_valid and the beat steady until the handshake completes, and it writes the control doubleword only between packets. Under those conditions a result arrives for each end beat and the result queue pairs records with packets in order.

// File: rtl/tlp_cls_pkg.sv
package tlp_cls_pkg;

  typedef enum logic [1:0] {
    RC_ADDR  = 2'd0,
    RC_ID    = 2'd1,
    RC_IMPL  = 2'd2,
    RC_OTHER = 2'd3
  } route_cls_e;

  typedef struct packed {
    logic       has_data;
    logic       hdr4;
    logic [4:0] typ;
    logic [2:0] tc;
    logic       digest;
    logic [9:0] len;
  } dw0_f_t;

  function automatic dw0_f_t f_unpack(input logic [31:0] dw);
    dw0_f_t f;
    f.has_data = dw[30];
    f.hdr4     = dw[29];
    f.typ      = dw[28:24];
    f.tc       = dw[22:20];
    f.digest   = dw[15];
    f.len      = dw[9:0];
    return f;
  endfunction

  function automatic route_cls_e f_class(input logic [4:0] typ);
    if (typ[4:1] == 4'b0000 || typ == 5'b00010) return RC_ADDR;
    if (typ[4:1] == 4'b0010)                    return RC_ID;
    if (typ[4:3] == 2'b10)                      return RC_IMPL;
    return RC_OTHER;
  endfunction

  // configuration, IO and message types must carry class 0 downstream
  function automatic logic f_tc0_only(input logic [4:0] typ);
    return (typ == 5'b00010) || (typ[4:1] == 4'b0010) || (typ[4:3] == 2'b10);
  endfunction

  function automatic logic [2:0] f_hdr_beats(input logic hdr4);
    return hdr4 ? 3'd4 : 3'd3;
  endfunction

  function automatic logic f_len_bad(input logic [9:0] len, input int unsigned max_dw);
    return (len == 10'd0) || (32'(len) > max_dw);
  endfunction

  function automatic logic [10:0] f_expect_payload(input logic [9:0] len, input logic dig);
    return {1'b0, len} + {10'd0, dig};
  endfunction

endpackage

// File: rtl/tlp_iso_ctrl.sv
module tlp_iso_ctrl #(
  parameter logic [7:0] CTRL_ADDR  = 8'h40,
  parameter int         EN_BIT     = 26,
  parameter int         TC_LSB     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic        iso_en,
  output logic [2:0]  iso_tc
);
  logic hit;
  assign hit = wr && (addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iso_en <= 1'b0;
      iso_tc <= 3'd0;
    end else if (hit) begin
      iso_en <= wdata[EN_BIT];
      iso_tc <= wdata[TC_LSB +: 3];
    end
  end

  // R8: a cycle without a matching write leaves the control state alone
  a_r8_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(iso_en) && $stable(iso_tc));
endmodule

// File: rtl/tlp_dw0_decode.sv
module tlp_dw0_decode
  import tlp_cls_pkg::*;
(
  input  logic [31:0] dw,
  output dw0_f_t      fld,
  output route_cls_e  cls,
  output logic        tc0_only,
  output logic [2:0]  route,
  output logic [2:0]  hdr_beats
);
  logic dw_unused;
  assign dw_unused = ^{dw[31], dw[23], dw[19:16], dw[14:10]};

  always_comb begin
    fld       = f_unpack(dw);
    cls       = f_class(fld.typ);
    tc0_only  = f_tc0_only(fld.typ);
    route     = (cls == RC_IMPL) ? fld.typ[2:0] : 3'd0;
    hdr_beats = f_hdr_beats(fld.hdr4);
  end
endmodule

// File: rtl/tlp_len_check.sv
module tlp_len_check
  import tlp_cls_pkg::*;
#(
  parameter int MAX_PAYLOAD_DW = 64,
  parameter int CNT_W          = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       sop,
  input  logic       eop,
  input  logic [2:0] hdr_beats,
  input  logic       has_data,
  input  logic [9:0] len,
  input  logic       digest,
  output logic       short_pkt,
  output logic       len_bad,
  output logic       cnt_mismatch
);
  localparam int TW = (CNT_W + 1 > 11) ? CNT_W + 1 : 11;

  logic [CNT_W-1:0] cnt_q, idx;
  logic [TW-1:0]    total, payload, expect_pl;

  assign idx       = sop ? '0 : cnt_q;
  assign total     = TW'(idx) + TW'(1);
  assign payload   = total - TW'(hdr_beats);
  assign expect_pl = TW'(f_expect_payload(len, digest));

  assign short_pkt    = total < TW'(hdr_beats);
  assign len_bad      = has_data && f_len_bad(len, MAX_PAYLOAD_DW);
  assign cnt_mismatch = has_data && !short_pkt && (payload != expect_pl);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (acc)   cnt_q <= eop ? '0 : ((idx == '1) ? idx : idx + 1'b1);
  end

  // R5: a one-beat packet can never hold a full header
  a_r5_single_beat_short: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sop && eop) |-> short_pkt);
  // R4: the beat counter restarts after every end beat
  a_r4_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && eop) |=> (cnt_q == '0));
endmodule

// File: rtl/tlp_hdr_classifier.sv
module tlp_hdr_classifier
  import tlp_cls_pkg::*;
#(
  parameter int         MAX_PAYLOAD_DW = 64,
  parameter int         CNT_W          = 8,
  parameter logic [7:0] CTRL_ADDR      = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic        in_up,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [1:0]  res_class,
  output logic [2:0]  res_route,
  output logic        res_hdr4,
  output logic        res_has_data,
  output logic [2:0]  res_tc,
  output logic        res_malformed
);
  logic        iso_en;
  logic [2:0]  iso_tc;
  logic        acc, eop_acc, res_stall;
  logic [31:0] held_dw, cur_dw;
  logic        held_up, cur_up;
  dw0_f_t      fld;
  route_cls_e  cls;
  logic        tc0_only, short_pkt, len_bad, cnt_mismatch, tc_bad, mal_now;
  logic [2:0]  route, hdr_beats, tc_now;

  tlp_iso_ctrl #(.CTRL_ADDR(CTRL_ADDR), .EN_BIT(26), .TC_LSB(16)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .iso_en(iso_en), .iso_tc(iso_tc));

  assign res_stall = res_valid && !res_ready;
  assign in_ready  = !res_stall;
  assign acc       = in_valid && in_ready;
  assign eop_acc   = acc && in_eop;
  assign cur_dw    = in_sop ? in_data : held_dw;
  assign cur_up    = in_sop ? in_up : held_up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_dw <= '0;
      held_up <= 1'b0;
    end else if (acc && in_sop) begin
      held_dw <= in_data;
      held_up <= in_up;
    end
  end

  tlp_dw0_decode u_dec (
    .dw(cur_dw), .fld(fld), .cls(cls), .tc0_only(tc0_only),
    .route(route), .hdr_beats(hdr_beats));

  tlp_len_check #(.MAX_PAYLOAD_DW(MAX_PAYLOAD_DW), .CNT_W(CNT_W)) u_len (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sop(in_sop), .eop(in_eop),
    .hdr_beats(hdr_beats), .has_data(fld.has_data), .len(fld.len),
    .digest(fld.digest), .short_pkt(short_pkt), .len_bad(len_bad),
    .cnt_mismatch(cnt_mismatch));

  assign tc_bad  = !cur_up && tc0_only && (fld.tc != 3'd0);
  assign mal_now = short_pkt || len_bad || cnt_mismatch || tc_bad;
  assign tc_now  = cur_up ? (iso_en ? iso_tc : 3'd0) : fld.tc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_class     <= 2'd0;
      res_route     <= 3'd0;
      res_hdr4      <= 1'b0;
      res_has_data  <= 1'b0;
      res_tc        <= 3'd0;
      res_malformed <= 1'b0;
    end else if (eop_acc) begin
      res_valid     <= 1'b1;
      res_class     <= cls;
      res_route     <= route;
      res_hdr4      <= fld.hdr4;
      res_has_data  <= fld.has_data;
      res_tc        <= tc_now;
      res_malformed <= mal_now;
    end else if (res_ready) begin
      res_valid     <= 1'b0;
    end
  end

  // R9: a taken record disappears unless a new one lands in the same cycle
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !eop_acc) |=> !res_valid);
  // R9: a stalled record holds every field
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_stall |=> res_valid && $stable({res_class, res_route, res_hdr4,
                                        res_has_data, res_tc, res_malformed}));
  // R9: nothing is accepted while a record waits
  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    res_stall |-> !acc);
  // R6: class rule violation on a downstream strict type reaches the record
  a_r6_tc_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_acc && !cur_up && tc0_only && fld.tc != 3'd0) |=> res_malformed);
  // R2: address-class decode reaches the record
  a_r2_addr_class: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_acc && cls == RC_ADDR) |=> res_valid && res_class == 2'd0);
endmodule

// File: tb/sim_tlp_hdr_classifier.sv
module sim_tlp_hdr_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_addr = 8'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_up = 1'b0;
  logic [31:0] in_data = 32'h0;
  logic res_ready = 1'b0;
  logic in_ready, res_valid, res_hdr4, res_has_data, res_malformed;
  logic [1:0] res_class;
  logic [2:0] res_route, res_tc;

  always #4 clk = ~clk;

  tlp_hdr_classifier u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_up(in_up),
    .res_valid(res_valid), .res_ready(res_ready), .res_class(res_class),
    .res_route(res_route), .res_hdr4(res_hdr4), .res_has_data(res_has_data),
    .res_tc(res_tc), .res_malformed(res_malformed));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // record packing: {class[1:0], route[2:0], hdr4, has_data, tc[2:0], mal}
  logic [10:0] exp_q[$];
  logic [10:0] cur_exp;
  logic [31:0] pkt [0:79];
  int          pkt_nb;
  logic        pkt_up;
  bit          m_iso = 0;
  logic [2:0]  m_tc = 3'd0;
  bit          chk_arrival = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] b_class(input logic [4:0] t);
    case (t)
      5'b00000, 5'b00001, 5'b00010: return 2'd0;
      5'b00100, 5'b00101:           return 2'd1;
      default:                      return (t[4:3] == 2'b10) ? 2'd2 : 2'd3;
    endcase
  endfunction

  function automatic bit b_strict(input logic [4:0] t);
    return (t == 5'b00010) || (t == 5'b00100) || (t == 5'b00101) || (t[4:3] == 2'b10);
  endfunction

  // builds pkt[], pkt_nb and cur_exp; delta adds/removes payload beats, short_n>0 truncates
  task automatic mk_pkt(input logic [1:0] fmt, input logic [4:0] typ, input logic [2:0] tc,
                        input bit dig, input logic [9:0] len, input bit up,
                        input int delta, input int short_n);
    int hb, pl;
    bit has, mal, shrt;
    logic [2:0] etc;
    has = fmt[1];
    hb  = fmt[0] ? 4 : 3;
    if (has) pl = (len != 0 && len <= 70) ? int'(len) + int'(dig) + delta : 2 + delta;
    else     pl = int'(dig);
    pkt_nb = (short_n > 0) ? short_n : hb + pl;
    pkt_up = up;
    pkt[0] = {1'b0, fmt, typ, 1'b0, tc, 4'h0, dig, 1'b0, 2'b00, 2'b00, len};
    for (int i = 1; i < 80; i++) pkt[i] = $urandom;
    shrt = pkt_nb < hb;
    mal  = shrt;
    if (has && (len == 0 || len > 64)) mal = 1;                       // R3
    if (has && !shrt && (pkt_nb - hb) != int'(len) + int'(dig)) mal = 1; // R4
    if (!up && b_strict(typ) && tc != 0) mal = 1;                    // R6
    etc = up ? (m_iso ? m_tc : 3'd0) : tc;                           // R6 R7
    cur_exp = {b_class(typ), (b_class(typ) == 2'd2) ? typ[2:0] : 3'd0,
               fmt[0], fmt[1], etc, mal};
  endtask

  task automatic monitor();
    if (chk_arrival) begin
      check(res_valid === 1'b1, "R9 arrival", res_valid, 1);
      chk_arrival = 0;
    end
    if (res_valid && !res_ready)
      check(in_ready === 1'b0, "R9 stall", in_ready, 0);
    if (res_valid && res_ready) begin
      logic [10:0] e;
      if (exp_q.size() == 0) begin
        check(0, "R9 spurious", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check(res_class === e[10:9], "R2 class", res_class, e[10:9]);
        check(res_route === e[8:6], "R2 route", res_route, e[8:6]);
        check(res_hdr4 === e[5] && res_has_data === e[4], "R1 format",
              {res_hdr4, res_has_data}, e[5:4]);
        check(res_tc === e[3:1], "R6 R7 tc", res_tc, e[3:1]);
        check(res_malformed === e[0], "R3 R4 R5 R6 malformed", res_malformed, e[0]);
      end
    end
  endtask

  task automatic idle(input int n, input bit rdy_rand);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; in_sop = 0; in_eop = 0;
      cfg_wr = 0;
      res_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
      #1 monitor();
    end
  endtask

  task automatic send_pkt();
    int i = 0;
    while (i < pkt_nb) begin
      @(negedge clk);
      res_ready = ($urandom % 4) != 0;
      in_valid = 1; in_data = pkt[i]; in_sop = (i == 0);
      in_eop = (i == pkt_nb - 1); in_up = pkt_up;
      #1 monitor();
      if (in_ready) begin
        if (i == pkt_nb - 1) begin
          exp_q.push_back(cur_exp);
          chk_arrival = 1;
        end
        i++;
      end
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    idle(4, 0);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    res_ready = 1;
    #1 monitor();
    if (a == 8'h40) begin m_iso = d[26]; m_tc = d[18:16]; end
  endtask

  task automatic run(input logic [1:0] fmt, input logic [4:0] typ, input logic [2:0] tc,
                     input bit dig, input logic [9:0] len, input bit up,
                     input int delta, input int short_n);
    mk_pkt(fmt, typ, tc, dig, len, up, delta, short_n);
    send_pkt();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(res_valid === 1'b0, "R9 reset valid", res_valid, 0);
    check(in_ready === 1'b1, "R9 reset ready", in_ready, 1);
    // directed corners
    run(2'b00, 5'b00000, 3'd5, 0, 10'd1, 0, 0, 0);   // R6 memory any class
    run(2'b10, 5'b00000, 3'd0, 0, 10'd1, 0, 0, 0);   // R1 3dw with data
    run(2'b11, 5'b00001, 3'd0, 1, 10'd64, 0, 0, 0);  // R3 max length, digest R4
    run(2'b10, 5'b00000, 3'd0, 0, 10'd65, 0, 0, 0);  // R3 too long
    run(2'b10, 5'b00000, 3'd0, 0, 10'd0, 0, 0, 0);   // R3 zero length
    run(2'b10, 5'b00010, 3'd0, 0, 10'd1, 0, 0, 0);   // R2 IO
    run(2'b00, 5'b00100, 3'd1, 0, 10'd1, 0, 0, 0);   // R6 config non-zero class
    run(2'b01, 5'b10100, 3'd0, 0, 10'd0, 0, 0, 0);   // R2 message route 4
    run(2'b11, 5'b10011, 3'd2, 0, 10'd3, 0, 0, 0);   // R6 message class 2
    run(2'b10, 5'b00000, 3'd0, 0, 10'd4, 0, 1, 0);   // R4 extra beat
    run(2'b11, 5'b00000, 3'd0, 1, 10'd4, 0, -1, 0);  // R4 missing beat
    run(2'b01, 5'b00000, 3'd0, 0, 10'd0, 0, 0, 2);   // R5 short header
    run(2'b00, 5'b00000, 3'd0, 0, 10'd0, 0, 0, 1);   // R5 single beat
    run(2'b00, 5'b01010, 3'd0, 0, 10'd0, 0, 0, 0);   // R2 other type
    run(2'b00, 5'b00000, 3'd6, 0, 10'd0, 1, 0, 0);   // R8 reset: upstream class 0
    cfg_write(8'h44, 32'h0405_0000);                 // R8 wrong address ignored
    run(2'b00, 5'b00000, 3'd6, 0, 10'd0, 1, 0, 0);
    cfg_write(8'h40, 32'h0405_0000);                 // R7 enable, class 5
    run(2'b00, 5'b00100, 3'd6, 0, 10'd0, 1, 0, 0);
    run(2'b00, 5'b00100, 3'd3, 0, 10'd0, 0, 0, 0);   // R7 downstream unaffected
    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [1:0] fmt;
      logic [4:0] typ;
      logic [9:0] len;
      int delta, sh, hb;
      logic [4:0] tl [0:7];
      tl = '{5'b00000, 5'b00001, 5'b00010, 5'b00100, 5'b00101, 5'b10000, 5'b10101, 5'b01010};
      if (n == 200) cfg_write(8'h40, {5'b0, 1'b1, 7'b0, 3'($urandom % 7 + 1), 16'h0});
      if (n == 300) cfg_write(8'h40, 32'h0);
      fmt = 2'($urandom);
      typ = tl[$urandom % 8];
      hb  = fmt[0] ? 4 : 3;
      case ($urandom % 10)
        0:       len = 10'd0;
        1:       len = 10'(65 + $urandom % 40);
        default: len = 10'(1 + $urandom % 64);
      endcase
      delta = (fmt[1] && ($urandom % 10) == 0) ? (($urandom % 2) ? 1 : -1) : 0;
      sh    = (($urandom % 20) == 0) ? 1 + int'($urandom % (hb - 1)) : 0;
      mk_pkt(fmt, typ, (($urandom % 2) ? 3'd0 : 3'($urandom)), 1'($urandom),
             len, 1'($urandom), delta, sh);
      send_pkt();
      if (($urandom % 4) == 0) idle(1 + $urandom % 3, 1);
    end
    idle(6, 0);
    check(exp_q.size() == 0, "R9 all results", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule